// File: doc/BRIEF.md
# Jittered PWM Switching Clock Generator

This block derives the switching-cycle timing of a current-mode PWM controller from a fixed system clock. It counts out one switching period after another. Each period starts with a one-clock `cycle_start` pulse, and the gate-enable window opens on that same clock. The window closes at a maximum-duty limit, or earlier when the current-trip input is seen. A current trip can only end the window after a minimum on-time blanking interval has passed. That interval is reported on its own output.

The nominal frequency is picked by one input: the slower setting is 60 kHz and the faster one is 120 kHz. The period is not held fixed. A slow stepped triangle pushes it above and below the nominal value by about 7%, with a full sweep taking about 1/260 s. This spreads the energy of the switching harmonics. A new period, and the duty limit that goes with it, are latched only when a cycle begins.

Protection logic elsewhere can ask for a cycle to be skipped through `skip_next`. The timing of a skipped cycle is unchanged, but the gate stays low for the whole of it. All counts below assume the default 24 MHz system clock.

Top module: `pwm_jit_clkgen`

## Requirements
- R1: While `rst_n` is low, `gate_en`, `cycle_start`, `min_on_blank` and `on_done` are all low. On the first clock edge after release a cycle begins. `cycle_start` and `gate_en` are both high on that clock, and the jitter restarts from the nominal period.
- R2: With `freq_hi`=0 the nominal period is 400 system clocks (60 kHz). With `freq_hi`=1 it is 200 system clocks (120 kHz).
- R3: Each period is the nominal value plus trunc(k*A/16). A is 7% of nominal, so A is 28 clocks at 60 kHz. The level k starts at 0 and moves by one every 1442 clocks: up to +16, down to -16, then back. At 60 kHz, periods therefore range from 372 to 428 clocks.
- R4: At 60 kHz, two consecutive periods differ by at most 2 clocks, and a difference of 2 does occur.
- R5: The gate rises only on a `cycle_start` clock. If no trip arrives, it stays high for floor(period*75/100) clocks: 300 for a 400-clock period and 150 for a 200-clock period.
- R6: If `cur_trip` is high at the clock edge that moves the cycle count to c ≥ 8, the gate is low from count c onward. A trip applied once 50 clocks of the cycle have elapsed gives 51 gate-high clocks.
- R7: The minimum on-time is 8 clocks, which is 300 ns rounded up. A trip held from the start of the cycle still leaves the gate high for exactly 8 clocks. `min_on_blank` is high for the first 8 clocks of every on-time.
- R8: `skip_next` is sampled on the edge that begins a cycle. If it is high, the gate stays low for that whole cycle, while `cycle_start` and the period length are unaffected. The next cycle gates normally.
- R9: `on_done` is low on each `cycle_start` clock. It goes high on the clock on which the gate falls and stays high until the next cycle. It stays low throughout a skipped cycle.
- R10: A change on `freq_hi` during a cycle leaves that cycle's period untouched. It takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (24 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_hi | input | 1 | 0: 60 kHz nominal, 1: 120 kHz nominal |
| cur_trip | input | 1 | Peak-current trip, ends on-time after blanking |
| skip_next | input | 1 | Suppresses the gate for the cycle starting at this edge |
| cycle_start | output | 1 | One-clock pulse at the first clock of each cycle |
| gate_en | output | 1 | Gate-enable window |
| min_on_blank | output | 1 | High during the minimum on-time of the gate |
| on_done | output | 1 | On-time of the current cycle has ended |

## Verification
The bench drives a trip from the very first clock of a cycle. A design that let the trip through during blanking would end the pulse after one clock instead of eight. It also drives a trip late in the on-time, which would expose an extra or missing clock of latency. A full jitter sweep is timed cycle by cycle. This catches a triangle that saturates short of ±16, one that steps by more than one level, and one that applies a new period part way through a cycle. The skip and frequency-change scenarios show whether a design lets these inputs act in the middle of a cycle instead of only at the cycle boundary. They also show whether a skip wrongly stretches or shortens the period.

// File: rtl/pwm_jit_pkg.sv
// Shared helpers for the jittered switching clock generator.
// Assumes: integer arguments small enough for 32-bit arithmetic.
package pwm_jit_pkg;

    // Direction of the triangular jitter sweep.
    typedef enum logic {
        SWEEP_DOWN = 1'b0,
        SWEEP_UP   = 1'b1
    } sweep_dir_e;

    // Integer division rounded up.
    function automatic int div_ceil(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/pwm_jit_tri.sv
// Stepped triangular jitter level generator.
// Produces a signed level that walks 0 -> +HALF -> -HALF -> 0, one step
// every STEP_CLKS clocks, each level held for one step interval.
// Assumes: STEP_CLKS >= 2, HALF >= 1, LW wide enough for +/-HALF.
module pwm_jit_tri
    import pwm_jit_pkg::*;
#(
    parameter int STEP_CLKS = 1442,
    parameter int HALF      = 16,
    parameter int LW        = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic signed [LW-1:0] level
);
    localparam int TW = $clog2(STEP_CLKS);
    localparam logic [TW-1:0]        TMR_LAST = TW'(STEP_CLKS - 1);
    localparam logic signed [LW-1:0] LV_MAX   = LW'(HALF);
    localparam logic signed [LW-1:0] LV_MIN   = -LW'(HALF);
    localparam logic signed [LW-1:0] LV_ONE   = LW'(1);

    logic [TW-1:0] tmr;
    sweep_dir_e    dir;

    // Step timer and triangle walk; reset restarts at level 0 heading up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr   <= '0;
            level <= '0;
            dir   <= SWEEP_UP;
        end else if (tmr == TMR_LAST) begin
            tmr <= '0;
            if (dir == SWEEP_UP) begin
                if (level == LV_MAX) begin
                    level <= level - LV_ONE;
                    dir   <= SWEEP_DOWN;
                end else begin
                    level <= level + LV_ONE;
                end
            end else begin
                if (level == LV_MIN) begin
                    level <= level + LV_ONE;
                    dir   <= SWEEP_UP;
                end else begin
                    level <= level - LV_ONE;
                end
            end
        end else begin
            tmr <= tmr + TW'(1);
        end
    end

    // R3
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level <= LV_MAX) && (level >= LV_MIN));

    // R4
    level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == $past(level)) || (level == $past(level) + LV_ONE) ||
        (level == $past(level) - LV_ONE));

endmodule

// File: rtl/pwm_per_calc.sv
// Period and duty-limit calculator.
// Selects the nominal period, adds the scaled jitter offset
// trunc(level*amp/HALF), and derives the maximum on-time as
// floor(period*DMAX_PCT/100). Purely combinational.
// Assumes: the largest period fits in PW bits.
module pwm_per_calc #(
    parameter int NOM_LO   = 400,
    parameter int NOM_HI   = 200,
    parameter int AMP_LO   = 28,
    parameter int AMP_HI   = 14,
    parameter int HALF     = 16,
    parameter int DMAX_PCT = 75,
    parameter int LW       = 6,
    parameter int PW       = 9
) (
    input  logic                 sel_hi,
    input  logic signed [LW-1:0] level,
    output logic [PW-1:0]        per,
    output logic [PW-1:0]        lim
);
    int nom;
    int amp;
    int off;
    int p;

    // Nominal plus jitter offset, then duty limit from the result.
    always_comb begin
        nom = sel_hi ? NOM_HI : NOM_LO;
        amp = sel_hi ? AMP_HI : AMP_LO;
        off = (int'(level) * amp) / HALF;
        p   = nom + off;
        per = PW'(p);
        lim = PW'((p * DMAX_PCT) / 100);
    end

endmodule

// File: rtl/pwm_jit_clkgen.sv
// Jittered PWM switching clock generator (top).
// Counts switching periods from the system clock. The period and duty limit
// are latched at each cycle start. The gate opens at cycle start unless a
// skip is requested, and closes at the duty limit or on a current trip
// after minimum on-time blanking.
// Assumes: F_LO_HZ < F_HI_HZ, minimum on-time shorter than the duty limit.
module pwm_jit_clkgen
    import pwm_jit_pkg::*;
#(
    parameter int CLK_HZ     = 24_000_000,
    parameter int F_LO_HZ    = 60_000,
    parameter int F_HI_HZ    = 120_000,
    parameter int JIT_PCT    = 7,
    parameter int JIT_HALF   = 16,
    parameter int JIT_MOD_HZ = 260,
    parameter int DMAX_PCT   = 75,
    parameter int TMIN_NS    = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic freq_hi,
    input  logic cur_trip,
    input  logic skip_next,
    output logic cycle_start,
    output logic gate_en,
    output logic min_on_blank,
    output logic on_done
);
    localparam int NOM_LO    = CLK_HZ / F_LO_HZ;
    localparam int NOM_HI    = CLK_HZ / F_HI_HZ;
    localparam int AMP_LO    = (NOM_LO * JIT_PCT) / 100;
    localparam int AMP_HI    = (NOM_HI * JIT_PCT) / 100;
    localparam int STEP_CLKS = CLK_HZ / (JIT_MOD_HZ * 4 * JIT_HALF);
    localparam int MINON     = div_ceil(TMIN_NS * (CLK_HZ / 1000), 1_000_000);
    localparam int LW        = $clog2(JIT_HALF + 1) + 1;
    localparam int PW        = $clog2(NOM_LO + AMP_LO + 1);
    localparam logic [PW-1:0] MINON_V = PW'(MINON);
    localparam logic [PW-1:0] PER_MIN = PW'(NOM_HI - AMP_HI);
    localparam logic [PW-1:0] PER_MAX = PW'(NOM_LO + AMP_LO);

    logic signed [LW-1:0] level;
    logic [PW-1:0] per_nx, lim_nx;
    logic [PW-1:0] cnt, per_q, lim_q;
    logic          cs_q, on_q, done_q;
    logic          wrap, trip_end, lim_end, on_end;
    logic [PW-1:0] cnt_nx;

    pwm_jit_tri #(
        .STEP_CLKS(STEP_CLKS),
        .HALF     (JIT_HALF),
        .LW       (LW)
    ) u_tri (
        .clk  (clk),
        .rst_n(rst_n),
        .level(level)
    );

    pwm_per_calc #(
        .NOM_LO  (NOM_LO),
        .NOM_HI  (NOM_HI),
        .AMP_LO  (AMP_LO),
        .AMP_HI  (AMP_HI),
        .HALF    (JIT_HALF),
        .DMAX_PCT(DMAX_PCT),
        .LW      (LW),
        .PW      (PW)
    ) u_calc (
        .sel_hi(freq_hi),
        .level (level),
        .per   (per_nx),
        .lim   (lim_nx)
    );

    // Cycle-boundary and on-time termination conditions.
    always_comb begin
        cnt_nx   = cnt + PW'(1);
        wrap     = (cnt == per_q - PW'(1));
        trip_end = cur_trip && (cnt_nx >= MINON_V);
        lim_end  = (cnt_nx == lim_q);
        on_end   = on_q && (trip_end || lim_end);
    end

    // Period counter; a period of 1 in reset forces a cycle start on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            per_q <= PW'(1);
            lim_q <= '0;
            cs_q  <= 1'b0;
        end else begin
            cs_q <= wrap;
            if (wrap) begin
                cnt   <= '0;
                per_q <= per_nx;
                lim_q <= lim_nx;
            end else begin
                cnt <= cnt_nx;
            end
        end
    end

    // Gate window and on-time-ended flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q   <= 1'b0;
            done_q <= 1'b0;
        end else if (wrap) begin
            on_q   <= !skip_next;
            done_q <= 1'b0;
        end else if (on_end) begin
            on_q   <= 1'b0;
            done_q <= 1'b1;
        end
    end

    assign cycle_start  = cs_q;
    assign gate_en      = on_q;
    assign min_on_blank = on_q && (cnt < MINON_V);
    assign on_done      = done_q;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !gate_en && !cycle_start && !on_done);

    // R3
    period_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> (per_q >= PER_MIN) && (per_q <= PER_MAX));

    // R5
    duty_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> (cnt < lim_q));

    // R5
    gate_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> cycle_start);

    // R7
    min_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_en) |-> (cnt >= MINON_V));

    // R8
    skip_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && $past(skip_next)) |-> !gate_en);

    // R8
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> !cycle_start);

    // R9
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> !on_done);

endmodule

// File: tb/pwm_jit_clkgen_bench.sv
// Directed bench for the jittered switching clock generator.
// Expected counts follow the requirements at the default 24 MHz scaling.
module pwm_jit_clkgen_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic freq_hi = 1'b0;
    logic cur_trip = 1'b0;
    logic skip_next = 1'b0;
    logic cycle_start, gate_en, min_on_blank, on_done;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    pwm_jit_clkgen u_pwm_jit_clkgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .freq_hi     (freq_hi),
        .cur_trip    (cur_trip),
        .skip_next   (skip_next),
        .cycle_start (cycle_start),
        .gate_en     (gate_en),
        .min_on_blank(min_on_blank),
        .on_done     (on_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reset, check quiet outputs, release; returns on the first cycle_start clock.
    task automatic do_reset(input logic hi);
        @(negedge clk);
        rst_n   = 1'b0;
        freq_hi = hi;
        cur_trip = 1'b0;
        skip_next = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 gate in reset", gate_en, 0);
        chk("R1 start in reset", cycle_start, 0);
        chk("R1 done in reset", on_done, 0);
        chk("R1 blank in reset", min_on_blank, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // From a cycle_start clock, count clocks to the next one.
    task automatic meas_period(output int p);
        p = 0;
        do begin
            @(negedge clk);
            p++;
        end while (!cycle_start);
    endtask

    // From a cycle_start clock, count gate-high and blank-high clocks.
    task automatic meas_on(output int n_on, output int n_blank);
        n_on = 0;
        n_blank = 0;
        while (gate_en) begin
            n_on++;
            if (min_on_blank) n_blank++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_and_lo;
        int p, n_on, n_bl;
        do_reset(1'b0);
        chk("R1 first start", cycle_start, 1);
        chk("R1 first gate", gate_en, 1);
        meas_on(n_on, n_bl);
        chk("R5 max on 60k", n_on, 300);
        chk("R9 done after duty end", on_done, 1);
        chk("R7 blank length", n_bl, 8);
        while (!cycle_start) @(negedge clk);
        chk("R9 done cleared", on_done, 0);
        meas_period(p);
        chk("R2 period 60k", p, 400);
    endtask

    task automatic t_hi;
        int p, n_on, n_bl;
        do_reset(1'b1);
        meas_on(n_on, n_bl);
        chk("R5 max on 120k", n_on, 150);
        while (!cycle_start) @(negedge clk);
        meas_period(p);
        chk("R2 period 120k", p, 200);
    endtask

    task automatic t_trip_blank;
        int n_on, n_bl;
        do_reset(1'b0);
        cur_trip = 1'b1;
        meas_on(n_on, n_bl);
        chk("R7 trip in blanking", n_on, 8);
        chk("R7 blank with trip", n_bl, 8);
        chk("R9 done after trip", on_done, 1);
        cur_trip = 1'b0;
    endtask

    task automatic t_trip_late;
        int n_on, n_bl;
        do_reset(1'b0);
        fork
            begin
                repeat (50) @(negedge clk);
                cur_trip = 1'b1;
            end
            meas_on(n_on, n_bl);
        join
        cur_trip = 1'b0;
        chk("R6 trip after blanking", n_on, 51);
    endtask

    task automatic t_skip;
        int p;
        int g_seen, d_seen;
        do_reset(1'b0);
        repeat (399) @(negedge clk);
        skip_next = 1'b1;
        @(negedge clk);
        skip_next = 1'b0;
        chk("R8 start still pulses", cycle_start, 1);
        chk("R8 gate suppressed", gate_en, 0);
        p = 0;
        g_seen = 0;
        d_seen = 0;
        do begin
            @(negedge clk);
            p++;
            if (!cycle_start && gate_en) g_seen++;
            if (!cycle_start && on_done) d_seen++;
        end while (!cycle_start);
        chk("R8 skipped period", p, 400);
        chk("R8 no gate in skip", g_seen, 0);
        chk("R9 no done in skip", d_seen, 0);
        chk("R8 gate resumes", gate_en, 1);
    endtask

    task automatic t_freq_change;
        int p1, p2;
        do_reset(1'b0);
        fork
            begin
                repeat (10) @(negedge clk);
                freq_hi = 1'b1;
            end
            meas_period(p1);
        join
        meas_period(p2);
        chk("R10 current cycle kept", p1, 400);
        chk("R10 next cycle new freq", p2, 200);
        freq_hi = 1'b0;
    endtask

    task automatic t_sweep;
        int p, prev, pmin, pmax, dmax, el, d;
        do_reset(1'b0);
        meas_period(p);
        chk("R3 first period nominal", p, 400);
        prev = p;
        pmin = p;
        pmax = p;
        dmax = 0;
        el = p;
        while (el < 93000) begin
            meas_period(p);
            el += p;
            d = (p > prev) ? p - prev : prev - p;
            if (d > dmax) dmax = d;
            if (p > pmax) pmax = p;
            if (p < pmin) pmin = p;
            prev = p;
        end
        chk("R3 longest period", pmax, 428);
        chk("R3 shortest period", pmin, 372);
        chk("R4 largest step", dmax, 2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset_and_lo();
        t_hi();
        t_trip_blank();
        t_trip_late();
        t_skip();
        t_freq_change();
        t_sweep();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule